// File: doc/BRIEF.md
# Block Write-Protection Lock Manager

This block holds a write-protection flag for every erase block of a flash array. Each flag is in one of three states: unlocked, locked, or lock-tight. Lock-tight is sticky. It resists both lock and unlock, and it can only be placed on a block that is not currently unlocked. Software selects an inclusive range of blocks through a low-bound register and a high-bound register. It then issues one of three range commands (unlock, lock, lock-tight) or a whole-array unlock command.

A sequential walker applies an accepted command one block per clock and raises `done` for a single cycle when it finishes. It also raises `done` when it aborts on an index beyond the array, and in that case it sets `cmd_err`. A status register records the code of the most recent block whose state actually changed. Program and erase engines use a combinational query port to ask whether a given block may be written.

Top module: `wp_lock_mgr`

## Requirements
- R1: After reset every block reads locked, `wp_status` reads 3'b010, and `busy`, `done` and `cmd_err` are low.
- R2: Block codes are one-hot: lock-tight 3'b001, locked 3'b010, unlocked 3'b100. `q_state` returns the code of block `q_block`. `q_writable` is 1 only for an unlocked block. A `q_block` at or above NUM_BLOCKS returns code 3'b000 with `q_writable` 0.
- R3: Command 8'h23 unlocks blocks `range_lo` to `range_hi` inclusive. Command 8'h2A locks that same range.
- R4: Lock and unlock leave any lock-tight block unchanged.
- R5: Command 8'h2C sets lock-tight on every block of the range, except blocks that are currently unlocked, which stay unchanged.
- R6: Command 8'h27 unlocks every block from 0 to NUM_BLOCKS-1, except lock-tight blocks, whatever the range registers hold.
- R7: Each block whose code changes copies its new code into `wp_status`. A block that is skipped or already holds the target code leaves `wp_status` unchanged.
- R8: A write to the low-bound register (`start_wr`) loads the low IDXW bits of `wr_val` into both `range_lo` and `range_hi`. A write to the high-bound register (`end_wr`) loads only `range_hi`. When both strobes are high in the same cycle, the `start_wr` write wins.
- R9: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. One block is handled per clock, and `done` is high for exactly one cycle, n edges after the accepting edge, where n is the number of blocks handled. When `range_lo` is greater than `range_hi`, no block is touched and `done` follows the accepting edge directly.
- R10: If the walk reaches an index at or above NUM_BLOCKS, it sets `cmd_err`, stops, and raises `done` on that step. The blocks handled before that index keep their new codes. `cmd_err` is cleared when the next command is accepted.
- R11: A command strobe while `busy` is high, or a code other than 8'h23, 8'h27, 8'h2A and 8'h2C, has no effect: no block changes and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Write strobe for the low-bound register (also loads the high bound) |
| end_wr | input | 1 | Write strobe for the high-bound register |
| wr_val | input | VAL_W | Register write value; the low IDXW bits are kept |
| range_lo | output | IDXW | Current low bound of the block range |
| range_hi | output | IDXW | Current high bound of the block range |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| busy | output | 1 | High while a range walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| cmd_err | output | 1 | The last command hit an out-of-array index |
| wp_status | output | 3 | Code of the block that changed most recently |
| q_block | input | IDXW | Block index to query |
| q_state | output | 3 | Protection code of the queried block |
| q_writable | output | 1 | Queried block is unlocked |

## Verification
A wrong per-block flag stays hidden until the query port selects that block. For that reason the bench reads every block through `q_state` after each command, so a corrupted flag shows up within the same idle window. A walker that is off by one block, or that fails to stop at the bound, shows directly as a `done` pulse at the wrong cycle count, counted from the accepting edge. It can also show as a neighbouring block that changed when it should not have. Skip-rule faults can only be seen through a later command. The bench therefore runs lock and unlock over lock-tight blocks, and runs lock-tight over unlocked blocks, and compares the results with `wp_status`, which moves only when a block really changes.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

    // One-hot protection codes held per block
    typedef enum logic [2:0] {
        PROT_TIGHT    = 3'b001,
        PROT_LOCKED   = 3'b010,
        PROT_UNLOCKED = 3'b100
    } prot_e;

    // Operation applied to each block of a walk
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_UNLOCK = 2'd1,
        OP_LOCK   = 2'd2,
        OP_TIGHT  = 2'd3
    } op_e;

    localparam logic [7:0] CMD_UNLOCK_RANGE = 8'h23;
    localparam logic [7:0] CMD_UNLOCK_ALL   = 8'h27;
    localparam logic [7:0] CMD_LOCK_RANGE   = 8'h2A;
    localparam logic [7:0] CMD_TIGHT_RANGE  = 8'h2C;

    // Decoded command: operation plus whole-array flag
    typedef struct packed {
        op_e  op;
        logic whole;
    } cmd_s;

    function automatic cmd_s decode_cmd(input logic [7:0] code);
        cmd_s c;
        c.op    = OP_NONE;
        c.whole = 1'b0;
        case (code)
            CMD_UNLOCK_RANGE: c.op = OP_UNLOCK;
            CMD_UNLOCK_ALL:   begin c.op = OP_UNLOCK; c.whole = 1'b1; end
            CMD_LOCK_RANGE:   c.op = OP_LOCK;
            CMD_TIGHT_RANGE:  c.op = OP_TIGHT;
            default:          c.op = OP_NONE;
        endcase
        return c;
    endfunction

    // Next code of one block under an operation, honouring the skip rules
    function automatic prot_e next_prot(input op_e op, input prot_e cur);
        prot_e n;
        n = cur;
        case (op)
            OP_UNLOCK: if (cur != PROT_TIGHT)    n = PROT_UNLOCKED;
            OP_LOCK:   if (cur != PROT_TIGHT)    n = PROT_LOCKED;
            OP_TIGHT:  if (cur != PROT_UNLOCKED) n = PROT_TIGHT;
            default:   n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
    parameter int IDXW  = 5,
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_wr,
    input  logic             end_wr,
    input  logic [VAL_W-1:0] wr_val,
    output logic [IDXW-1:0]  lo,
    output logic [IDXW-1:0]  hi
);

    logic [IDXW-1:0] masked;
    assign masked = wr_val[IDXW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else if (start_wr) begin
            // Low-bound write mirrors into the high bound
            lo <= masked;
            hi <= masked;
        end else if (end_wr) begin
            hi <= masked;
        end
    end

endmodule

// File: rtl/wp_range_walker.sv
module wp_range_walker
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 20,
    parameter int IDXW       = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic [IDXW-1:0] lo,
    input  logic [IDXW-1:0] hi,
    output logic            busy,
    output logic            done,
    output logic            cmd_err,
    output logic            step_valid,
    output logic [IDXW-1:0] step_idx,
    output op_e             step_op
);

    localparam logic [IDXW:0]   LIMIT    = (IDXW+1)'(NUM_BLOCKS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_BLOCKS - 1);

    typedef enum logic {W_IDLE, W_RUN} walk_e;

    walk_e           state_q;
    logic [IDXW-1:0] idx_q;
    logic [IDXW-1:0] end_q;
    op_e             op_q;
    cmd_s            dec;
    logic            out_of_range;

    assign dec          = decode_cmd(cmd_code);
    assign out_of_range = ({1'b0, idx_q} >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            idx_q   <= '0;
            end_q   <= '0;
            op_q    <= OP_NONE;
            done    <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                W_IDLE: begin
                    if (cmd_valid && dec.op != OP_NONE) begin
                        cmd_err <= 1'b0;
                        op_q    <= dec.op;
                        if (dec.whole) begin
                            idx_q   <= '0;
                            end_q   <= LAST_IDX;
                            state_q <= W_RUN;
                        end else if (lo > hi) begin
                            // Empty range: finish without touching a block
                            done <= 1'b1;
                        end else begin
                            idx_q   <= lo;
                            end_q   <= hi;
                            state_q <= W_RUN;
                        end
                    end
                end
                W_RUN: begin
                    if (out_of_range) begin
                        cmd_err <= 1'b1;
                        done    <= 1'b1;
                        state_q <= W_IDLE;
                    end else if (idx_q == end_q) begin
                        done    <= 1'b1;
                        state_q <= W_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == W_RUN);
    assign step_valid = busy && !out_of_range;
    assign step_idx   = idx_q;
    assign step_op    = op_q;

endmodule

// File: rtl/wp_flag_array.sv
module wp_flag_array
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 20,
    parameter int IDXW       = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_valid,
    input  logic [IDXW-1:0] step_idx,
    input  op_e             step_op,
    input  logic [IDXW-1:0] q_block,
    output logic [2:0]      wp_status,
    output logic [2:0]      q_state,
    output logic            q_writable
);

    prot_e flags [NUM_BLOCKS];
    prot_e cur_code;
    prot_e new_code;
    prot_e status_q;

    // Code of the block under the walker
    always_comb begin
        cur_code = PROT_LOCKED;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (step_idx == IDXW'(b)) cur_code = flags[b];
        end
    end

    assign new_code = next_prot(step_op, cur_code);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
        prot_e cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= PROT_LOCKED;
            end else if (step_valid && step_idx == IDXW'(b)) begin
                cell_q <= new_code;
            end
        end
        assign flags[b] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= PROT_LOCKED;
        end else if (step_valid && new_code != cur_code) begin
            status_q <= new_code;
        end
    end

    assign wp_status = status_q;

    // Query port for program and erase engines
    always_comb begin
        q_state = 3'b000;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (q_block == IDXW'(b)) q_state = flags[b];
        end
    end

    assign q_writable = (q_state == PROT_UNLOCKED);

endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr
    import wp_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 20,
    parameter int VAL_W      = 16,
    localparam int IDXW      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_wr,
    input  logic             end_wr,
    input  logic [VAL_W-1:0] wr_val,
    output logic [IDXW-1:0]  range_lo,
    output logic [IDXW-1:0]  range_hi,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    output logic             busy,
    output logic             done,
    output logic             cmd_err,
    output logic [2:0]       wp_status,
    input  logic [IDXW-1:0]  q_block,
    output logic [2:0]       q_state,
    output logic             q_writable
);

    logic            step_valid;
    logic [IDXW-1:0] step_idx;
    op_e             step_op;

    wp_range_regs #(.IDXW(IDXW), .VAL_W(VAL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .start_wr (start_wr),
        .end_wr   (end_wr),
        .wr_val   (wr_val),
        .lo       (range_lo),
        .hi       (range_hi)
    );

    wp_range_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDXW(IDXW)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .lo         (range_lo),
        .hi         (range_hi),
        .busy       (busy),
        .done       (done),
        .cmd_err    (cmd_err),
        .step_valid (step_valid),
        .step_idx   (step_idx),
        .step_op    (step_op)
    );

    wp_flag_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDXW(IDXW)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .step_valid (step_valid),
        .step_idx   (step_idx),
        .step_op    (step_op),
        .q_block    (q_block),
        .wp_status  (wp_status),
        .q_state    (q_state),
        .q_writable (q_writable)
    );

endmodule

// File: rtl/wp_lock_mgr_chk.sv
module wp_lock_mgr_chk #(
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            start_wr,
    input logic [IDXW-1:0] range_lo,
    input logic [IDXW-1:0] range_hi,
    input logic            busy,
    input logic            done,
    input logic            cmd_err,
    input logic [2:0]      wp_status,
    input logic [IDXW-1:0] q_block,
    input logic [2:0]      q_state
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_status_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(wp_status) == 1);

    assert_tight_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (q_state == 3'b001) |=> ((q_block != $past(q_block)) || (q_state == 3'b001)));

    assert_start_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (range_lo == range_hi));

    assert_err_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_err) |-> done);

endmodule

bind wp_lock_mgr wp_lock_mgr_chk #(.IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_wr  (start_wr),
    .range_lo  (range_lo),
    .range_hi  (range_hi),
    .busy      (busy),
    .done      (done),
    .cmd_err   (cmd_err),
    .wp_status (wp_status),
    .q_block   (q_block),
    .q_state   (q_state)
);

// File: tb/wp_lock_mgr_tb.sv
`timescale 1ns/1ps
module wp_lock_mgr_tb;

    localparam int NB = 20;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_wr = 1'b0;
    logic          end_wr = 1'b0;
    logic [15:0]   wr_val = '0;
    logic [IW-1:0] range_lo, range_hi;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic          busy, done, cmd_err;
    logic [2:0]    wp_status;
    logic [IW-1:0] q_block = '0;
    logic [2:0]    q_state;
    logic          q_writable;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_state [NB];
    logic [2:0] m_stat;
    logic       m_err;
    int         m_lo, m_hi;

    always #2.5 clk = ~clk;

    wp_lock_mgr #(.NUM_BLOCKS(NB), .VAL_W(16)) u_dut (
        .clk(clk), .rst(rst), .start_wr(start_wr), .end_wr(end_wr),
        .wr_val(wr_val), .range_lo(range_lo), .range_hi(range_hi),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .busy(busy),
        .done(done), .cmd_err(cmd_err), .wp_status(wp_status),
        .q_block(q_block), .q_state(q_state), .q_writable(q_writable)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] m_next(input logic [7:0] code, input logic [2:0] cur);
        if ((code == 8'h23 || code == 8'h27) && cur != 3'b001) return 3'b100;
        if (code == 8'h2A && cur != 3'b001) return 3'b010;
        if (code == 8'h2C && cur != 3'b100) return 3'b001;
        return cur;
    endfunction

    task automatic m_touch(input logic [7:0] code, input int b);
        logic [2:0] nv;
        nv = m_next(code, m_state[b]);
        if (nv != m_state[b]) begin
            m_state[b] = nv;
            m_stat     = nv;
        end
    endtask

    task automatic model_cmd(input logic [7:0] code, output int n);
        n     = 0;
        m_err = 1'b0;
        if (code == 8'h27) begin
            for (int b = 0; b < NB; b++) m_touch(code, b);
            n = NB;
        end else if (m_lo <= m_hi) begin
            for (int b = m_lo; b <= m_hi; b++) begin
                n++;
                if (b >= NB) begin
                    m_err = 1'b1;
                    break;
                end
                m_touch(code, b);
            end
        end
    endtask

    task automatic check_blocks(input string req);
        for (int b = 0; b < NB; b++) begin
            q_block = IW'(b);
            #0.1;
            check(q_state == m_state[b], req, $sformatf("q_state blk %0d", b),
                  q_state, m_state[b]);
            check(q_writable == (m_state[b] == 3'b100), req, $sformatf("q_writable blk %0d", b),
                  q_writable, m_state[b] == 3'b100);
        end
    endtask

    task automatic wr_start(input logic [15:0] v);
        @(negedge clk); start_wr = 1'b1; wr_val = v;
        @(negedge clk); start_wr = 1'b0;
        m_lo = v & 16'h1F;
        m_hi = m_lo;
        check(range_lo == IW'(m_lo) && range_hi == IW'(m_hi), "R8", "start write",
              {range_lo, range_hi}, {IW'(m_lo), IW'(m_hi)});
    endtask

    task automatic wr_end(input logic [15:0] v);
        @(negedge clk); end_wr = 1'b1; wr_val = v;
        @(negedge clk); end_wr = 1'b0;
        m_hi = v & 16'h1F;
        check(range_lo == IW'(m_lo) && range_hi == IW'(m_hi), "R8", "end write",
              {range_lo, range_hi}, {IW'(m_lo), IW'(m_hi)});
    endtask

    task automatic run_cmd(input logic [7:0] code, input string req);
        int n, cnt;
        model_cmd(code, n);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk); cmd_valid = 1'b0;
        cnt = 0;
        while (!done && cnt < 64) begin
            @(negedge clk);
            cnt++;
        end
        check(done == 1'b1, "R9", "done seen", done, 1);
        check(cnt == n, req, $sformatf("cycles to done cmd %0h", code), cnt, n);
        check(cmd_err == m_err, "R10", "cmd_err", cmd_err, m_err);
        check(wp_status == m_stat, "R7", "wp_status", wp_status, m_stat);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", {done, busy}, 0);
        check_blocks(req);
    endtask

    task automatic t_reset;
        check(busy == 0 && done == 0 && cmd_err == 0, "R1", "control after reset",
              {busy, done, cmd_err}, 0);
        check(wp_status == 3'b010, "R1", "status after reset", wp_status, 3'b010);
        check_blocks("R1");
    endtask

    task automatic t_regs;
        wr_start(16'd3);
        wr_end(16'd7);
        wr_start(16'h0045);
        @(negedge clk); start_wr = 1'b1; end_wr = 1'b1; wr_val = 16'd9;
        @(negedge clk); start_wr = 1'b0; end_wr = 1'b0;
        m_lo = 9; m_hi = 9;
        check(range_lo == 5'd9 && range_hi == 5'd9, "R8", "simultaneous writes",
              {range_lo, range_hi}, {5'd9, 5'd9});
    endtask

    task automatic t_ranges;
        wr_start(16'd3); wr_end(16'd7);
        run_cmd(8'h23, "R3");
        wr_start(16'd2); wr_end(16'd5);
        run_cmd(8'h2C, "R5");
        wr_start(16'd10); wr_end(16'd11);
        run_cmd(8'h2A, "R7");
        wr_start(16'd0); wr_end(16'd4);
        run_cmd(8'h23, "R4");
        wr_start(16'd0); wr_end(16'd6);
        run_cmd(8'h2A, "R4");
    endtask

    task automatic t_all;
        wr_start(16'd7); wr_end(16'd8);
        run_cmd(8'h27, "R6");
        @(negedge clk); q_block = 5'd25; #0.1;
        check(q_state == 3'b000 && q_writable == 1'b0, "R2", "query beyond array",
              {q_state, q_writable}, 0);
    endtask

    task automatic t_empty;
        wr_start(16'd9); wr_end(16'd4);
        run_cmd(8'h2A, "R9");
    endtask

    task automatic t_error;
        wr_start(16'd18); wr_end(16'd25);
        run_cmd(8'h2A, "R10");
        wr_start(16'd1);
        run_cmd(8'h2C, "R10");
    endtask

    task automatic t_ignore;
        int dones, first, n;
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h55;
        @(negedge clk); cmd_valid = 1'b0;
        dones = 0;
        for (int i = 0; i < 6; i++) begin
            if (done || busy) dones++;
            @(negedge clk);
        end
        check(dones == 0, "R11", "unknown code activity", dones, 0);
        check_blocks("R11");
        wr_start(16'd5); wr_end(16'd15);
        model_cmd(8'h2A, n);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h2A;
        @(negedge clk); cmd_valid = 1'b0;
        dones = 0; first = -1;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (i == 3) begin cmd_valid = 1'b1; cmd_code = 8'h2C; end
            if (i == 4) cmd_valid = 1'b0;
            if (done) begin
                dones++;
                if (first < 0) first = i;
            end
        end
        check(dones == 1, "R11", "done pulses with busy strobe", dones, 1);
        check(first == n, "R11", "done cycle with busy strobe", first, n);
        check(wp_status == m_stat, "R11", "status after busy strobe", wp_status, m_stat);
        check_blocks("R11");
    endtask

    initial begin
        for (int b = 0; b < NB; b++) m_state[b] = 3'b010;
        m_stat = 3'b010; m_err = 1'b0; m_lo = 0; m_hi = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_ranges();
        t_all();
        t_empty();
        t_error();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule